// File: doc/BRIEF.md
# Beacon Timer Unit

This block keeps the station's 64-bit time synchronization counter and four 16-bit timers that mark the beacon schedule. The counter advances by one on every microsecond tick. The timers hold, in order, the next beacon time, the DMA alert time, the software alert time and the end of the announcement window. A time unit is 1024 counter steps, so bits [25:10] of the counter give the 16-bit time-unit value that each timer is compared against.

When the time-unit value equals a timer's stored value, that timer moves forward by the beacon interval. While beaconing is enabled, the timer also raises a one-cycle event. A timer that the counter has jumped past is not moved again until the 16-bit time-unit value comes back round to it. The two alert timers hold values in eighths of a time unit.

Software reaches the block through a small register port. A side load port lets received-beacon logic overwrite the counter directly. A window flag tells whether the announcement-window timer and the DMA alert timer still sit where they should relative to the next beacon time.

Top module: `beacon_timer_unit`

## Requirements
- R1: After reset, the counter, the low-word holding register, all four timers, the interval, the enable bit, the reset toggle, the events and every read value are zero.
- R2: The counter rises by exactly one on each cycle with `us_tick` high and holds otherwise. Reads at address 0 return counter bits [31:0] and reads at address 1 return bits [63:32].
- R3: A write to address 0 only stores a holding word and leaves the counter unchanged. A write to address 1 loads the counter with {written word, held word}, and this takes priority over a tick.
- R4: When `load_en` is high, the counter takes `load_val`. This has priority over a high-word write and over a tick.
- R5: A write to address 6 with bit 17 set flips the reset toggle, which reads back at bit 17. A flip from 0 to 1 clears the counter at that edge, ahead of all other updates. A flip from 1 to 0 leaves the counter alone.
- R6: Timers 0 and 3 (addresses 2 and 5) are compared with counter bits [25:10]. On a match, the timer gains the interval (address 6 bits [15:0]) modulo 2^16 at that clock edge. A register write to a timer overrides this update.
- R7: Timers 1 and 2 (addresses 3 and 4) are compared with the time-unit value shifted left by 3, truncated to 16 bits. On a match they gain the interval shifted left by 3, modulo 2^16.
- R8: Bit i of `evt` is high for one cycle, in the cycle after timer i matched, only if the enable bit (address 6 bit 16) was set. A match with the enable bit clear still moves the timer but raises no event.
- R9: A timer whose value the counter skips over keeps that value until the time-unit field equals it again, for example after a wrap of bit 26.
- R10: `win_ok` is the logical AND of two checks, with interval I. The first check is on timer 0 (A) and timer 3 (B) with gap 1. The second is on timer 1 divided by 8 (A) and timer 0 (B) with gap DMA_LEAD (default 2). A check holds if any of these is true: B−A equals the gap; A−B equals I−gap; A+65536−B equals I−gap; B+65536−A equals the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-microsecond tick enable |
| load_en | input | 1 | Overwrite counter from `load_val` |
| load_val | input | 64 | Counter value to load |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0..6) |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address (0..6) |
| rd_data | output | 32 | Combinational read data |
| evt | output | 4 | Per-timer event pulses |
| win_ok | output | 1 | Timer window rule satisfied |

## Verification
The timers are started from a counter loaded just below their targets. With beaconing enabled, this shows that each timer fires once and moves by the right step at whole-unit and at eighth-unit resolution. The same schedule run again with beaconing disabled tells gated events apart from timer movement. A jump of the counter past two alert timers, followed by a load that lands the time-unit field back below them with bit 26 set, tells a skipped timer apart from one that compares on ordering rather than equality. Timer triples are then written for each of the four window cases and one failing case, and a reference model compares the events, the window flag and the read port on every clock.

// File: rtl/beacon_timer_unit.sv
module beacon_timer_unit #(
  parameter int TMR_W      = 16,
  parameter int TU_SHIFT   = 10,
  parameter int FINE_SHIFT = 3,
  parameter int DMA_LEAD   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        load_en,
  input  logic [63:0] load_val,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic [3:0]  evt,
  output logic        win_ok
);
  localparam int NT = 4;
  localparam int EW = TMR_W + 3;
  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, A_T0 = 3'd2, A_CTL = 3'd6;
  localparam int ARM_BIT = TMR_W + 1;

  logic [63:0]       tsf_q;
  logic [31:0]       hold_q;
  logic [TMR_W-1:0]  tmr_q [NT];
  logic [TMR_W-1:0]  per_q;
  logic              en_q, arm_q;
  logic [NT-1:0]     hit;
  logic [TMR_W-1:0]  tu, fine_tu, fine_per;
  logic              ctl_wr, clr;

  assign tu       = tsf_q[TU_SHIFT +: TMR_W];
  assign fine_tu  = tu << FINE_SHIFT;
  assign fine_per = per_q << FINE_SHIFT;
  assign ctl_wr   = wr_en && wr_addr == A_CTL;
  assign clr      = ctl_wr && wr_data[ARM_BIT] && !arm_q;

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_cmp
      if (g == 1 || g == 2) begin : g_fine
        assign hit[g] = tmr_q[g] == fine_tu;
      end else begin : g_unit
        assign hit[g] = tmr_q[g] == tu;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) tmr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (wr_en && wr_addr == A_T0 + 3'(i))
          tmr_q[i] <= wr_data[TMR_W-1:0];
        else if (hit[i])
          tmr_q[i] <= tmr_q[i] + ((i == 1 || i == 2) ? fine_per : per_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsf_q  <= '0;
      hold_q <= '0;
      per_q  <= '0;
      en_q   <= 1'b0;
      arm_q  <= 1'b0;
      evt    <= '0;
    end else begin
      evt <= hit & {NT{en_q}};
      if (ctl_wr) begin
        per_q <= wr_data[TMR_W-1:0];
        en_q  <= wr_data[TMR_W];
        if (wr_data[ARM_BIT]) arm_q <= !arm_q;
      end
      if (wr_en && wr_addr == A_LO) hold_q <= wr_data;
      if (clr)                           tsf_q <= '0;
      else if (load_en)                  tsf_q <= load_val;
      else if (wr_en && wr_addr == A_HI) tsf_q <= {wr_data, hold_q};
      else if (us_tick)                  tsf_q <= tsf_q + 64'd1;
    end
  end

  function automatic logic win_fit(input logic [TMR_W-1:0] a, input logic [TMR_W-1:0] b,
                                   input logic [TMR_W-1:0] w, input logic [TMR_W-1:0] iv);
    logic signed [EW-1:0] sa, sb, sw, si, wr;
    sa = $signed({3'b000, a});
    sb = $signed({3'b000, b});
    sw = $signed({3'b000, w});
    si = $signed({3'b000, iv});
    wr = $signed({3'b001, {TMR_W{1'b0}}});
    return (sb - sa == sw) || (sa - sb == si - sw) ||
           (sa + wr - sb == si - sw) || (sb + wr - sa == sw);
  endfunction

  assign win_ok = win_fit(tmr_q[0], tmr_q[3], TMR_W'(1), per_q) &&
                  win_fit(tmr_q[1] >> FINE_SHIFT, tmr_q[0], TMR_W'(DMA_LEAD), per_q);

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = tsf_q[31:0];
      3'd1:    rd_data = tsf_q[63:32];
      3'd2:    rd_data = 32'(tmr_q[0]);
      3'd3:    rd_data = 32'(tmr_q[1]);
      3'd4:    rd_data = 32'(tmr_q[2]);
      3'd5:    rd_data = 32'(tmr_q[3]);
      3'd6:    rd_data = 32'({arm_q, en_q, per_q});
      default: rd_data = '0;
    endcase
  end

  AST_TSF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(us_tick && !load_en && !wr_en) |-> tsf_q == $past(tsf_q) + 64'd1); // R2
  AST_TSF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !$past(arm_q)) |-> tsf_q == 64'd0); // R5
  AST_ARM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr && wr_data[ARM_BIT]) |-> arm_q != $past(arm_q)); // R5
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |-> $past(en_q)); // R8
  AST_T0_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && !$past(wr_en && wr_addr == A_T0)) |-> tmr_q[0] == $past(tmr_q[0] + per_q)); // R6
endmodule

// File: tb/test_beacon_timer_unit.sv
module test_beacon_timer_unit;
  localparam int PER = 10;
  localparam int LEAD = 2;

  logic        clk = 0, rst_n = 0, us_tick = 0, load_en = 0, wr_en = 0;
  logic [63:0] load_val = '0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  evt;
  logic        win_ok;

  int checks = 0, errors = 0;
  int cnt [4] = '{0, 0, 0, 0};

  beacon_timer_unit i_beacon_timer_unit (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .load_en(load_en), .load_val(load_val),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt(evt), .win_ok(win_ok));

  always #(PER/2) clk = ~clk;

  longint unsigned m_tsf, m_hold;
  int m_tmr [4];
  int m_per;
  bit m_en, m_arm;
  bit [3:0] m_evt;

  always @(posedge clk) begin
    int tu;
    bit [3:0] hit;
    bit clr;
    if (!rst_n) begin
      m_tsf = 0; m_hold = 0; m_per = 0; m_en = 0; m_arm = 0; m_evt = 0;
      for (int i = 0; i < 4; i++) m_tmr[i] = 0;
    end else begin
      tu = int'((m_tsf >> 10) & 64'hFFFF);
      for (int i = 0; i < 4; i++)
        hit[i] = (i == 1 || i == 2) ? (m_tmr[i] == (tu * 8) % 65536) : (m_tmr[i] == tu);
      m_evt = hit & {4{m_en}};
      for (int i = 0; i < 4; i++) begin
        if (wr_en && int'(wr_addr) == i + 2) m_tmr[i] = int'(wr_data & 32'hFFFF);
        else if (hit[i]) m_tmr[i] = (m_tmr[i] + ((i == 1 || i == 2) ? m_per * 8 : m_per)) % 65536;
      end
      clr = 0;
      if (wr_en && wr_addr == 3'd6) begin
        m_per = int'(wr_data & 32'hFFFF);
        m_en = wr_data[16];
        if (wr_data[17]) begin clr = !m_arm; m_arm = !m_arm; end
      end
      if (clr) m_tsf = 0;
      else if (load_en) m_tsf = load_val;
      else if (wr_en && wr_addr == 3'd1) m_tsf = {wr_data, m_hold[31:0]};
      else if (us_tick) m_tsf = m_tsf + 1;
      if (wr_en && wr_addr == 3'd0) m_hold = wr_data;
    end
  end

  function automatic bit fits(int a, int b, int w, int iv);
    return (b - a == w) || (a - b == iv - w) || (a + 65536 - b == iv - w) || (b + 65536 - a == w);
  endfunction

  function automatic bit m_win();
    return fits(m_tmr[0], m_tmr[3], 1, m_per) && fits(m_tmr[1] / 8, m_tmr[0], LEAD, m_per);
  endfunction

  function automatic logic [31:0] m_rd(logic [2:0] a);
    case (a)
      3'd0: return m_tsf[31:0];
      3'd1: return m_tsf[63:32];
      3'd2, 3'd3, 3'd4, 3'd5: return 32'(m_tmr[int'(a) - 2]);
      3'd6: return {14'd0, m_arm, m_en, 16'(m_per)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 evt vs model", 64'(evt), 64'(m_evt));
    chk("R10 win_ok vs model", 64'(win_ok), 64'(m_win()));
    chk(rd_addr < 3'd2 ? "R2 counter read vs model" : "R6 register read vs model",
        64'(rd_data), 64'(m_rd(rd_addr)));
    for (int i = 0; i < 4; i++) if (evt[i]) cnt[i]++;
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc(); wr_en = 0;
  endtask
  task automatic exp_rd(logic [2:0] a, logic [31:0] e, string tag);
    rd_addr = a; #2; chk(tag, 64'(rd_data), 64'(e));
  endtask
  task automatic load(logic [63:0] v);
    load_en = 1; load_val = v; cyc(); load_en = 0;
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    for (int a = 0; a < 7; a++) exp_rd(3'(a), 0, "R1 reset value");
    chk("R1 evt after reset", 64'(evt), 0);
    us_tick = 1; repeat (20) cyc(); us_tick = 0;
    exp_rd(0, 20, "R2 twenty ticks");
    cyc(); exp_rd(0, 20, "R2 hold without tick");
    wr(0, 32'h1234_5678);
    exp_rd(0, 20, "R3 low write only held");
    wr(1, 32'h0000_00AB);
    exp_rd(0, 32'h1234_5678, "R3 low word committed");
    exp_rd(1, 32'hAB, "R3 high word committed");
    us_tick = 1; load(64'h0000_0001_0000_0FF0); us_tick = 0;
    exp_rd(0, 32'hFF0, "R4 load low beats tick");
    exp_rd(1, 32'h1, "R4 load high");
    wr(6, 32'h2_0000);
    exp_rd(0, 0, "R5 first toggle clears low");
    exp_rd(1, 0, "R5 first toggle clears high");
    exp_rd(6, 32'h2_0000, "R5 toggle armed");
    us_tick = 1; repeat (5) cyc(); us_tick = 0;
    wr(6, 32'h2_0000);
    exp_rd(0, 5, "R5 second toggle keeps counter");
    exp_rd(6, 0, "R5 toggle disarmed");
    wr(2, 50); wr(5, 51); wr(3, 384); wr(4, 360); wr(6, 32'h1_0064);
    load(64'(45 * 1024 - 3));
    us_tick = 1; repeat (7200) cyc(); us_tick = 0;
    exp_rd(2, 150, "R6 timer0 advanced");
    exp_rd(5, 151, "R6 timer3 advanced");
    exp_rd(3, 1184, "R7 timer1 fine advance");
    exp_rd(4, 1160, "R7 timer2 fine advance");
    for (int i = 0; i < 4; i++) chk("R8 one event per timer", 64'(cnt[i]), 1);
    chk("R10 case B=A+gap", 64'(win_ok), 1);
    wr(6, 32'h64);
    load(64'(150 * 1024 - 2));
    us_tick = 1; repeat (2100) cyc(); us_tick = 0;
    exp_rd(2, 250, "R6 timer0 moves while disabled");
    exp_rd(3, 1184, "R9 timer1 left behind");
    exp_rd(4, 1160, "R9 timer2 left behind");
    chk("R8 no event while disabled", 64'(cnt[0]), 1);
    wr(6, 32'h1_0064);
    load(64'h400_0000 + 64'(145 * 1024 - 2));
    us_tick = 1; repeat (4096) cyc(); us_tick = 0;
    exp_rd(4, 1960, "R9 timer2 caught after wrap");
    exp_rd(3, 1984, "R9 timer1 caught after wrap");
    exp_rd(2, 250, "R9 timer0 untouched");
    chk("R8 timer1 event count", 64'(cnt[1]), 2);
    chk("R8 timer2 event count", 64'(cnt[2]), 2);
    wr(6, 32'h64);
    wr(5, 151);
    chk("R10 case A advanced", 64'(win_ok), 1);
    wr(2, 10); wr(5, 65447); wr(3, 64);
    chk("R10 case A wrapped", 64'(win_ok), 1);
    wr(2, 65535); wr(5, 0); wr(3, 776);
    chk("R10 case B wrapped", 64'(win_ok), 1);
    wr(5, 5);
    chk("R10 bad window", 64'(win_ok), 0);
    repeat (3) cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule